// File: doc/BRIEF.md
# Parallel NOR Flash Pin Interface

This block sits at the pin boundary of an asynchronous parallel NOR flash and turns the raw active-low bus strobes into the device's bus modes: read, output disable, standby, deep power-down and write. It sits in a single clock domain. Every control strobe passes through a synchronizer before it is decoded, so the host must hold each strobe level for at least three clocks. The block steers read data from the array core onto the data lanes in either word or byte width. It captures the address and data of each write strobe and hands the pair to the command logic as a single-cycle event.

The block also drives the open-drain ready/busy pin, pulling it low from the write engine's busy flag. It answers the engine's array-alteration requests with a grant that combines the write-protect pin, the per-block lock bits and the programming-voltage lockout flag. When the reset/power-down pin is low, the block puts everything into a quiet state and holds the core in reset. When that pin is released, the core comes back up in read-array mode.

Top module: `pflash_bus_if`

## Requirements
- R1: The device counts as selected only when `ce_a_n` and `ce_b_n` are both low. With either enable high the data lanes are not driven and no write is captured.
- R2: While the synchronized `pwr_rst_n` is low, `dq_oe_lo`, `dq_oe_hi` and `sts_low` are all 0, `core_reset` is 1, no write strobe is captured and `alter_grant` is 0.
- R3: Within three clocks of `pwr_rst_n` returning high, `core_reset` falls to 0 so that the core restarts in read-array mode, and reads work again.
- R4: The lanes are driven only when the device is selected and powered with `oe_n` low and `we_n` high. Setting `oe_n` high disables both lane enables.
- R5: A low-to-high transition of `we_n`, seen while the device is selected and powered with `oe_n` high, gives exactly one cycle of `wr_valid` carrying the address and data present at the strobe.
- R6: With `byte_n` low (byte width), `dq_oe_hi` stays 0. A read returns core bits 7:0 on `dq_out[7:0]` when `addr[0]`=0 and core bits 15:8 when `addr[0]`=1. A write yields `wr_data` = {8'h00, dq_in[7:0]}, and `wr_addr` keeps bit 0.
- R7: With `byte_n` high (word width), `addr[0]` is ignored: both lanes carry the core word at `core_addr` = addr[20:1], and a captured `wr_addr` has bit 0 cleared.
- R8: `wr_block` reports the block number of the captured address, which is address bits 20:16 (32 blocks of 64 KB). `core_addr` is the byte address shifted right by one.
- R9: `sts_low` (pull the open-drain ready pin low) is 1 exactly when `busy` is 1 and the device is not in deep power-down. Otherwise the pin is released.
- R10: `alter_grant` is 0 whenever `vpp_lock` is 1. With `wp_n` low, a request is refused if it is a lock-bit change (`alter_lockcfg`=1) or if it targets a block whose bit in `lock_bits` is set. Any other request is granted.
- R11: When the device is selected and powered with `oe_n` and `we_n` both low, `dbg_clash` is 1 and neither lane enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low logic reset |
| ce_a_n | input | 1 | First chip enable, active low |
| ce_b_n | input | 1 | Second chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| pwr_rst_n | input | 1 | Reset / deep power-down, active low |
| byte_n | input | 1 | Low selects byte width, high selects word width |
| wp_n | input | 1 | Write-protect, active low |
| vpp_lock | input | 1 | Programming voltage below lockout |
| addr | input | 21 | Byte address from the bus |
| dq_in | input | 16 | Data lanes as driven by the host |
| dq_out | output | 16 | Data to place on the lanes |
| dq_oe_lo | output | 1 | Drive enable for lanes 7:0 |
| dq_oe_hi | output | 1 | Drive enable for lanes 15:8 |
| core_addr | output | 20 | Word address to the array core |
| core_rdata | input | 16 | Word read from the array core |
| core_reset | output | 1 | Holds internal automation in reset |
| wr_valid | output | 1 | One-cycle captured write event |
| wr_addr | output | 21 | Captured write address |
| wr_data | output | 16 | Captured write data |
| wr_block | output | 5 | Block number of the captured address |
| busy | input | 1 | Write engine busy flag |
| sts_low | output | 1 | Pull the open-drain ready pin low |
| alter_req | input | 1 | Engine asks to alter the array or lock bits |
| alter_lockcfg | input | 1 | Request is a lock-bit change |
| alter_block | input | 5 | Block targeted by the request |
| lock_bits | input | 32 | Per-block lock bits |
| alter_grant | output | 1 | Request allowed |
| dbg_clash | output | 1 | Illegal output-enable/write-enable overlap |

## Verification
The checker assumes that `byte_n`, `addr` and `dq_in` stay steady for the whole window in which a strobe passes through the synchronizer. It also assumes that the host never toggles a strobe faster than the three-clock minimum, so that every rising edge of `we_n` is seen as a separate event. The stimulus changes pins only on falling clock edges. It holds every strobe level for at least three clocks and keeps address and data fixed from before the fall of `we_n` until after `wr_valid` has appeared. Combinational inputs such as `busy`, `lock_bits` and the request fields are changed only between checks.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

   typedef enum logic [2:0] {
      BM_PDOWN,
      BM_STANDBY,
      BM_OUTDIS,
      BM_READ,
      BM_WRITE,
      BM_CLASH
   } bus_mode_e;

endpackage

// File: rtl/pflash_sync.sv
module pflash_sync #(
   parameter int              WIDTH   = 5,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= din;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= stage_q[s-1];
         end
      end
   endgenerate

   assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/pflash_mode_dec.sv
module pflash_mode_dec
   import pflash_pkg::*;
(
   input  logic      pwr_s_n,
   input  logic      ce_a_s_n,
   input  logic      ce_b_s_n,
   input  logic      oe_s_n,
   input  logic      we_s_n,
   output bus_mode_e mode
);

   always_comb begin
      if (!pwr_s_n)                    mode = BM_PDOWN;
      else if (ce_a_s_n || ce_b_s_n)   mode = BM_STANDBY;
      else if (!oe_s_n && !we_s_n)     mode = BM_CLASH;
      else if (!oe_s_n)                mode = BM_READ;
      else if (!we_s_n)                mode = BM_WRITE;
      else                             mode = BM_OUTDIS;
   end

endmodule

// File: rtl/pflash_wr_capture.sv
module pflash_wr_capture
   import pflash_pkg::*;
#(
   parameter int ADDR_W  = 21,
   parameter int DATA_W  = 16,
   parameter int BLK_LSB = 16,
   localparam int BLK_W  = ADDR_W - BLK_LSB,
   localparam int LANE_W = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_s_n,
   input  bus_mode_e         mode,
   input  logic              byte_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] dq_in,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [BLK_W-1:0]  wr_block
);

   logic we_d_n;
   logic strobe_rise;

   assign strobe_rise = we_s_n && !we_d_n && (mode == BM_OUTDIS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_d_n   <= 1'b1;
         wr_valid <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
         wr_block <= '0;
      end else begin
         we_d_n   <= we_s_n;
         wr_valid <= strobe_rise;
         if (strobe_rise) begin
            wr_block <= addr[ADDR_W-1:BLK_LSB];
            if (byte_n) begin
               wr_addr <= {addr[ADDR_W-1:1], 1'b0};
               wr_data <= dq_in;
            end else begin
               wr_addr <= addr;
               wr_data <= {{(DATA_W-LANE_W){1'b0}}, dq_in[LANE_W-1:0]};
            end
         end
      end
   end

endmodule

// File: rtl/pflash_protect.sv
module pflash_protect #(
   parameter int  BLK_W   = 5,
   localparam int NUM_BLK = 1 << BLK_W
) (
   input  logic               pdown,
   input  logic               wp_n,
   input  logic               vpp_lock,
   input  logic               alter_req,
   input  logic               alter_lockcfg,
   input  logic [BLK_W-1:0]   alter_block,
   input  logic [NUM_BLK-1:0] lock_bits,
   output logic               alter_grant
);

   logic blk_locked;
   logic wp_refuse;

   always_comb begin
      blk_locked  = lock_bits[alter_block];
      wp_refuse   = !wp_n && (alter_lockcfg || blk_locked);
      alter_grant = alter_req && !pdown && !vpp_lock && !wp_refuse;
   end

endmodule

// File: rtl/pflash_bus_if.sv
module pflash_bus_if
   import pflash_pkg::*;
#(
   parameter int  ADDR_W      = 21,
   parameter int  DATA_W      = 16,
   parameter int  BLK_LSB     = 16,
   parameter int  SYNC_STAGES = 2,
   localparam int BLK_W       = ADDR_W - BLK_LSB,
   localparam int NUM_BLK     = 1 << BLK_W,
   localparam int LANE_W      = DATA_W / 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ce_a_n,
   input  logic               ce_b_n,
   input  logic               oe_n,
   input  logic               we_n,
   input  logic               pwr_rst_n,
   input  logic               byte_n,
   input  logic               wp_n,
   input  logic               vpp_lock,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  dq_in,
   output logic [DATA_W-1:0]  dq_out,
   output logic               dq_oe_lo,
   output logic               dq_oe_hi,
   output logic [ADDR_W-2:0]  core_addr,
   input  logic [DATA_W-1:0]  core_rdata,
   output logic               core_reset,
   output logic               wr_valid,
   output logic [ADDR_W-1:0]  wr_addr,
   output logic [DATA_W-1:0]  wr_data,
   output logic [BLK_W-1:0]   wr_block,
   input  logic               busy,
   output logic               sts_low,
   input  logic               alter_req,
   input  logic               alter_lockcfg,
   input  logic [BLK_W-1:0]   alter_block,
   input  logic [NUM_BLK-1:0] lock_bits,
   output logic               alter_grant,
   output logic               dbg_clash
);

   generate
      if (DATA_W % 2 != 0) begin : g_bad_data_w
         $error("DATA_W must be even");
      end
      if (BLK_LSB < 1 || BLK_LSB >= ADDR_W) begin : g_bad_blk_lsb
         $error("BLK_LSB must fall inside the address");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   localparam int NPIN = 5;
   localparam logic [NPIN-1:0] PIN_RST = 5'b01111;

   logic [NPIN-1:0] pin_raw;
   logic [NPIN-1:0] pin_s;
   bus_mode_e       mode;
   logic [DATA_W-1:0] lane_word;

   assign pin_raw = {pwr_rst_n, ce_a_n, ce_b_n, oe_n, we_n};

   pflash_sync #(
      .WIDTH  (NPIN),
      .STAGES (SYNC_STAGES),
      .RST_VAL(PIN_RST)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_raw),
      .dout (pin_s)
   );

   pflash_mode_dec u_mode (
      .pwr_s_n (pin_s[4]),
      .ce_a_s_n(pin_s[3]),
      .ce_b_s_n(pin_s[2]),
      .oe_s_n  (pin_s[1]),
      .we_s_n  (pin_s[0]),
      .mode    (mode)
   );

   pflash_wr_capture #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .BLK_LSB(BLK_LSB)
   ) u_wr (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_s_n  (pin_s[0]),
      .mode    (mode),
      .byte_n  (byte_n),
      .addr    (addr),
      .dq_in   (dq_in),
      .wr_valid(wr_valid),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .wr_block(wr_block)
   );

   pflash_protect #(
      .BLK_W(BLK_W)
   ) u_prot (
      .pdown        (mode == BM_PDOWN),
      .wp_n         (wp_n),
      .vpp_lock     (vpp_lock),
      .alter_req    (alter_req),
      .alter_lockcfg(alter_lockcfg),
      .alter_block  (alter_block),
      .lock_bits    (lock_bits),
      .alter_grant  (alter_grant)
   );

   assign core_addr  = addr[ADDR_W-1:1];
   assign core_reset = (mode == BM_PDOWN);
   assign sts_low    = busy && (mode != BM_PDOWN);
   assign dbg_clash  = (mode == BM_CLASH);

   // byte width picks one half of the core word onto the low lanes
   always_comb begin
      if (byte_n) lane_word = core_rdata;
      else if (addr[0])
         lane_word = {{(DATA_W-LANE_W){1'b0}}, core_rdata[DATA_W-1:LANE_W]};
      else
         lane_word = {{(DATA_W-LANE_W){1'b0}}, core_rdata[LANE_W-1:0]};
   end

   assign dq_out   = lane_word;
   assign dq_oe_lo = (mode == BM_READ);
   assign dq_oe_hi = (mode == BM_READ) && byte_n;

endmodule

// File: rtl/pflash_bus_if_chk.sv
module pflash_bus_if_chk
   import pflash_pkg::*;
#(
   parameter int BLK_W   = 5,
   parameter int NUM_BLK = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               byte_n,
   input logic               wp_n,
   input logic               vpp_lock,
   input logic               dq_oe_lo,
   input logic               dq_oe_hi,
   input logic               sts_low,
   input logic               busy,
   input logic               wr_valid,
   input logic               alter_grant,
   input logic               alter_lockcfg,
   input logic [BLK_W-1:0]   alter_block,
   input logic [NUM_BLK-1:0] lock_bits,
   input logic               dbg_clash,
   input logic               core_reset,
   input bus_mode_e          mode
);

   p_standby_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BM_STANDBY) |-> !dq_oe_lo && !dq_oe_hi);

   p_pdown_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      core_reset |-> !dq_oe_lo && !dq_oe_hi && !sts_low && !alter_grant);

   p_drive_only_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe_lo || dq_oe_hi) |-> (mode == BM_READ));

   p_read_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BM_READ) |-> dq_oe_lo);

   p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid);

   p_byte_upper_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe_hi |-> byte_n);

   p_sts_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sts_low |-> busy && !core_reset);

   p_vpp_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
      alter_grant |-> !vpp_lock);

   p_wp_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (alter_grant && !wp_n) |-> !alter_lockcfg && !lock_bits[alter_block]);

   p_clash_no_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_clash |-> !dq_oe_lo && !dq_oe_hi);

endmodule

bind pflash_bus_if pflash_bus_if_chk #(
   .BLK_W  (BLK_W),
   .NUM_BLK(NUM_BLK)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .byte_n       (byte_n),
   .wp_n         (wp_n),
   .vpp_lock     (vpp_lock),
   .dq_oe_lo     (dq_oe_lo),
   .dq_oe_hi     (dq_oe_hi),
   .sts_low      (sts_low),
   .busy         (busy),
   .wr_valid     (wr_valid),
   .alter_grant  (alter_grant),
   .alter_lockcfg(alter_lockcfg),
   .alter_block  (alter_block),
   .lock_bits    (lock_bits),
   .dbg_clash    (dbg_clash),
   .core_reset   (core_reset),
   .mode         (mode)
);

// File: tb/pflash_bus_if_bench.sv
module pflash_bus_if_bench;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [20:0] a;
      logic [15:0] d;
      logic [4:0]  b;
   } wr_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_a_n = 1'b1, ce_b_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic        pwr_rst_n = 1'b1, byte_n = 1'b1, wp_n = 1'b1, vpp_lock = 1'b0;
   logic [20:0] addr = '0;
   logic [15:0] dq_in = '0;
   logic [15:0] dq_out;
   logic        dq_oe_lo, dq_oe_hi;
   logic [19:0] core_addr;
   logic [15:0] core_rdata;
   logic        core_reset, wr_valid;
   logic [20:0] wr_addr;
   logic [15:0] wr_data;
   logic [4:0]  wr_block;
   logic        busy = 1'b0, sts_low;
   logic        alter_req = 1'b0, alter_lockcfg = 1'b0;
   logic [4:0]  alter_block = '0;
   logic [31:0] lock_bits = 32'h0000_8001;
   logic        alter_grant, dbg_clash;

   int n_cmp = 0;
   int n_bad = 0;
   int wr_seen = 0;
   bit done = 0;
   wr_item_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   // array core stand-in: a fixed scramble of the word address
   assign core_rdata = {core_addr[7:0], core_addr[15:8]} ^ 16'h3C5A;

   pflash_bus_if u_pflash_bus_if (
      .clk(clk), .rst_n(rst_n), .ce_a_n(ce_a_n), .ce_b_n(ce_b_n),
      .oe_n(oe_n), .we_n(we_n), .pwr_rst_n(pwr_rst_n), .byte_n(byte_n),
      .wp_n(wp_n), .vpp_lock(vpp_lock), .addr(addr), .dq_in(dq_in),
      .dq_out(dq_out), .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi),
      .core_addr(core_addr), .core_rdata(core_rdata), .core_reset(core_reset),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_block(wr_block), .busy(busy), .sts_low(sts_low),
      .alter_req(alter_req), .alter_lockcfg(alter_lockcfg),
      .alter_block(alter_block), .lock_bits(lock_bits),
      .alter_grant(alter_grant), .dbg_clash(dbg_clash)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [15:0] word_at(input logic [20:0] a);
      logic [19:0] w;
      w = a[20:1];
      return {w[7:0], w[15:8]} ^ 16'h3C5A;
   endfunction

   // monitor: pops expected writes as the design reports them
   always @(negedge clk) begin
      if (rst_n && wr_valid) begin
         wr_seen++;
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R5: unexpected write actual %h/%h expected none", wr_addr, wr_data);
         end else begin
            wr_item_t e;
            e = exp_q.pop_front();
            check("R5/R7 write address", {11'd0, wr_addr}, {11'd0, e.a});
            check("R5/R6 write data", {16'd0, wr_data}, {16'd0, e.d});
            check("R8 write block", {27'd0, wr_block}, {27'd0, e.b});
         end
      end
   end

   task automatic do_write(input logic [20:0] a, input logic [15:0] d, input bit expect_it);
      wr_item_t e;
      addr = a; dq_in = d; oe_n = 1'b1; ce_a_n = 1'b0; ce_b_n = 1'b0; we_n = 1'b0;
      step(4);
      if (expect_it) begin
         e.a = byte_n ? {a[20:1], 1'b0} : a;
         e.d = byte_n ? d : {8'h00, d[7:0]};
         e.b = a[20:16];
         exp_q.push_back(e);
      end
      we_n = 1'b1;
      step(4);
      ce_a_n = 1'b1; ce_b_n = 1'b1;
      step(3);
   endtask

   task automatic do_read(input logic [20:0] a, input string tag);
      logic [15:0] w;
      w = word_at(a);
      addr = a; ce_a_n = 1'b0; ce_b_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
      step(3);
      check({tag, " lane lo enable"}, {31'd0, dq_oe_lo}, 32'd1);
      check({tag, " lane hi enable"}, {31'd0, dq_oe_hi}, {31'd0, byte_n});
      if (byte_n)
         check({tag, " word data"}, {16'd0, dq_out}, {16'd0, w});
      else
         check({tag, " byte data"}, {24'd0, dq_out[7:0]}, {24'd0, a[0] ? w[15:8] : w[7:0]});
      oe_n = 1'b1;
      step(3);
      check("R4 output disable", {30'd0, dq_oe_hi, dq_oe_lo}, 32'd0);
      ce_a_n = 1'b1; ce_b_n = 1'b1;
      step(3);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int seen0;
      step(2);
      // reset state: sync stages hold power-down
      check("R2 reset core_reset", {31'd0, core_reset}, 32'd1);
      check("R2 reset lanes", {30'd0, dq_oe_hi, dq_oe_lo}, 32'd0);
      check("R2 reset wr_valid", {31'd0, wr_valid}, 32'd0);
      check("R2 reset sts", {31'd0, sts_low}, 32'd0);
      rst_n = 1'b1;
      step(4);
      check("R3 powered after reset", {31'd0, core_reset}, 32'd0);

      // word-width reads, bit 0 ignored
      do_read(21'h012345, "R7 odd word read");
      do_read(21'h012344, "R7 even word read");
      check("R8 core word address", {12'd0, core_addr}, 32'h091A2);

      // standby with one enable high
      addr = 21'h000100; oe_n = 1'b0; ce_a_n = 1'b0; ce_b_n = 1'b1;
      step(3);
      check("R1 ce_b high no drive", {30'd0, dq_oe_hi, dq_oe_lo}, 32'd0);
      ce_a_n = 1'b1; ce_b_n = 1'b0;
      step(3);
      check("R1 ce_a high no drive", {30'd0, dq_oe_hi, dq_oe_lo}, 32'd0);
      ce_b_n = 1'b1; oe_n = 1'b1;
      step(3);

      // byte-width reads
      byte_n = 1'b0;
      do_read(21'h0A0F10, "R6 even byte read");
      do_read(21'h0A0F11, "R6 odd byte read");

      // writes
      byte_n = 1'b1;
      do_write(21'h1F0003, 16'hBEEF, 1);
      byte_n = 1'b0;
      do_write(21'h0A0001, 16'h12C3, 1);
      byte_n = 1'b1;
      seen0 = wr_seen;
      check("R5 two writes seen", wr_seen, 2);
      // one enable high: write ignored
      addr = 21'h050000; dq_in = 16'h7777; ce_a_n = 1'b0; ce_b_n = 1'b1; we_n = 1'b0;
      step(4);
      we_n = 1'b1;
      step(6);
      ce_a_n = 1'b1;
      check("R1 deselected write ignored", wr_seen, seen0);

      // clash
      addr = 21'h000200; ce_a_n = 1'b0; ce_b_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
      step(3);
      check("R11 clash flag", {31'd0, dbg_clash}, 32'd1);
      check("R11 clash no drive", {30'd0, dq_oe_hi, dq_oe_lo}, 32'd0);
      we_n = 1'b1;
      step(3);
      check("R11 clash cleared", {31'd0, dbg_clash}, 32'd0);
      oe_n = 1'b1; ce_a_n = 1'b1; ce_b_n = 1'b1;
      step(3);
      check("R11 no write from clash", wr_seen, seen0);

      // status pin
      busy = 1'b1;
      #1;
      check("R9 busy pulls low", {31'd0, sts_low}, 32'd1);
      busy = 1'b0;
      #1;
      check("R9 idle releases", {31'd0, sts_low}, 32'd0);

      // deep power-down
      busy = 1'b1; alter_req = 1'b1; alter_block = 5'd3;
      pwr_rst_n = 1'b0;
      step(3);
      check("R2 pdown core_reset", {31'd0, core_reset}, 32'd1);
      check("R2 pdown sts released", {31'd0, sts_low}, 32'd0);
      check("R2 pdown no grant", {31'd0, alter_grant}, 32'd0);
      addr = 21'h000010; ce_a_n = 1'b0; ce_b_n = 1'b0; oe_n = 1'b0;
      step(3);
      check("R2 pdown no drive", {30'd0, dq_oe_hi, dq_oe_lo}, 32'd0);
      oe_n = 1'b1; ce_a_n = 1'b1; ce_b_n = 1'b1;
      step(3);
      do_write(21'h030000, 16'h5555, 0);
      check("R2 pdown write ignored", wr_seen, seen0);
      busy = 1'b0; alter_req = 1'b0;
      pwr_rst_n = 1'b1;
      step(3);
      check("R3 core_reset released", {31'd0, core_reset}, 32'd0);
      do_read(21'h1ABCD6, "R3 read after wake");

      // protection
      alter_req = 1'b1;
      wp_n = 1'b0; alter_lockcfg = 1'b0; alter_block = 5'd0;
      #1 check("R10 wp low locked block", {31'd0, alter_grant}, 32'd0);
      alter_block = 5'd15;
      #1 check("R10 wp low locked block 15", {31'd0, alter_grant}, 32'd0);
      alter_block = 5'd1;
      #1 check("R10 wp low open block", {31'd0, alter_grant}, 32'd1);
      alter_lockcfg = 1'b1;
      #1 check("R10 wp low lock change", {31'd0, alter_grant}, 32'd0);
      wp_n = 1'b1; alter_block = 5'd0;
      #1 check("R10 wp high lock change", {31'd0, alter_grant}, 32'd1);
      alter_lockcfg = 1'b0;
      #1 check("R10 wp high locked block", {31'd0, alter_grant}, 32'd1);
      vpp_lock = 1'b1;
      #1 check("R10 vpp lockout", {31'd0, alter_grant}, 32'd0);
      vpp_lock = 1'b0; alter_req = 1'b0;
      #1 check("R10 no request", {31'd0, alter_grant}, 32'd0);

      step(3);
      check("R5 queue drained", exp_q.size(), 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule